// File: doc/BRIEF.md
# Multiplexed-Bus Address Demultiplexer and Segment Port

This block sits between an 8-bit microcontroller running from external memory and the parts on its board. The processor puts the low address byte and the data byte on one shared 8-bit port, one after the other, and marks the address phase with an address-strobe pulse. The block keeps that low byte and joins it with the high byte from a separate port, which gives a 16-bit address that stays valid for the rest of the bus cycle.

From that address and the processor's three active-low strobes (program fetch, data read, data write), the block drives the chip select and output enable of a 32 KB SRAM at 0x0000 to 0x7FFF. That SRAM holds both the program and the external data. The block also contains one output register for a seven-segment display. A data write to 0x7F55 loads that register and a write to any other address does not. Software shows a character by writing its segment pattern and blanks the display by writing zero.

All logic runs on one system clock. The strobes are sampled on that clock, so a write takes effect when the block sees the rising edge of the write strobe.

Top module: `segbus_glue`

## Requirements
- R1: While `addrStrobe` is high, `addrOut[7:0]` equals `busLow` in the same cycle, with no clock delay.
- R2: While `addrStrobe` is low, `addrOut[7:0]` holds the value `busLow` had at the last clock edge at which `addrStrobe` was high, whatever `busLow` carries afterwards.
- R3: `addrOut[15:8]` always equals `busHigh`.
- R4: `sramSelN` (active low) equals `addrOut[15]`. It is low for every address in 0x0000 to 0x7FFF and high for 0x8000 and above.
- R5: `sramOeN` (active low) is low exactly when (`fetchN` is low or `readN` is low) and `addrOut[15]` is 0. It is high during a write cycle.
- R6: A write loads `segOut` at the first clock edge that samples `writeN` high after a sample of it low. The value loaded is the `busLow` value from the last edge at which `writeN` was low. `segOut` keeps its old value while `writeN` is still low.
- R7: The load in R6 happens only if `addrOut` was exactly 0x7F55 while `writeN` was low. A write to any other address, including one that differs from 0x7F55 in a single bit, leaves `segOut` unchanged.
- R8: An active-low `rstN` clears `segOut` and the stored low address byte to 0x00 at once.
- R9: `segOut` bit 0 drives segment a and bit 6 drives segment g. A write of 0x00 turns every segment off, a write of 0x01 lights only bit 0 and a write of 0x40 lights only bit 6.
- R10: A read or program-fetch cycle at 0x7F55 leaves `segOut` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addrStrobe | input | 1 | Address-phase strobe on the shared port, active high |
| busLow | input | 8 | Shared low-address / data port |
| busHigh | input | 8 | High address byte |
| fetchN | input | 1 | Program fetch strobe, active low |
| readN | input | 1 | External data read strobe, active low |
| writeN | input | 1 | External data write strobe, active low |
| addrOut | output | 16 | Rebuilt 16-bit address |
| sramSelN | output | 1 | SRAM chip select, active low |
| sramOeN | output | 1 | SRAM output enable, active low |
| segOut | output | 8 | Display register; bit 0 = segment a, bit 6 = segment g |

## Verification
The bench writes to addresses that differ from 0x7F55 in only one bit: bit 15, bit 1 and bit 8. A comparator that checks too few bits, or ignores bit 15, loads the display on one of these writes. It also runs a read cycle and a fetch cycle at 0x7F55; a decoder that ignored which strobe was active would load the display from a read. It checks `segOut` while `writeN` is still low, and checks that a write of 0x00 blanks the display; a load on the wrong strobe edge, or one that took the data after the bus had moved on, would show the new value too early or show the wrong value. The bench checks the address and SRAM enables at 0x8000 and checks that the address stays latched after the port switches to data. A design that routed the port straight through, or derived the select from the wrong bit, would get these wrong.

// File: rtl/segglue_pkg.sv
package segglue_pkg;

  // Strobes passed from the control module to the datapath
  typedef struct packed {
    logic loadLow;    // address phase: low port carries address
    logic sampleWr;   // write strobe low: capture data candidate
    logic commitSeg;  // end of a matching write: load display
  } glueStrobes_t;

endpackage

// File: rtl/busCtrl.sv
module busCtrl
  import segglue_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] DISP_ADDR = 16'h7F55
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrStrobe,
  input  logic              fetchN,
  input  logic              readN,
  input  logic              writeN,
  input  logic [ADDR_W-1:0] addrFull,
  output glueStrobes_t      strobes,
  output logic              sramSelN,
  output logic              sramOeN
);

  localparam int SEL_BIT = ADDR_W - 1;

  logic wrPrevQ;
  logic hitQ;
  logic addrHit;
  logic inSram;

  assign addrHit = (addrFull == DISP_ADDR);
  assign inSram  = ~addrFull[SEL_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrevQ <= 1'b1;
      hitQ    <= 1'b0;
    end else begin
      wrPrevQ <= writeN;
      if (!writeN) hitQ <= addrHit;
    end
  end

  always_comb begin
    strobes.loadLow   = addrStrobe;
    strobes.sampleWr  = ~writeN;
    strobes.commitSeg = writeN & ~wrPrevQ & hitQ;
  end

  assign sramSelN = ~inSram;
  assign sramOeN  = ~(inSram & (~fetchN | ~readN));

  // R5: output enable can only be active with the chip selected
  a_r5_oe_implies_sel: assert property (@(posedge clk) disable iff (!rstN)
    !sramOeN |-> !sramSelN);

  // R7: a display load is preceded by the exact display address
  a_r7_commit_needs_match: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commitSeg |-> ($past(addrFull) == DISP_ADDR));

endmodule

// File: rtl/busDatapath.sv
module busDatapath
  import segglue_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  glueStrobes_t      strobes,
  input  logic [DATA_W-1:0] busLow,
  input  logic [ADDR_W-DATA_W-1:0] busHigh,
  output logic [ADDR_W-1:0] addrFull,
  output logic [DATA_W-1:0] segOut
);

  logic [DATA_W-1:0] lowQ;
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] segQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowQ  <= '0;
      dataQ <= '0;
      segQ  <= '0;
    end else begin
      if (strobes.loadLow)   lowQ  <= busLow;
      if (strobes.sampleWr)  dataQ <= busLow;
      if (strobes.commitSeg) segQ  <= dataQ;
    end
  end

  // Transparent while the strobe is high, stored value afterwards
  assign addrFull = {busHigh, strobes.loadLow ? busLow : lowQ};
  assign segOut   = segQ;

  // R2: the stored low byte does not move outside the address phase
  a_r2_low_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadLow |=> $stable(lowQ));

  // R6: the display changes only after a commit strobe
  a_r6_seg_only_on_commit: assert property (@(posedge clk) disable iff (!rstN)
    (segQ != $past(segQ)) |-> $past(strobes.commitSeg));

endmodule

// File: rtl/segbus_glue.sv
module segbus_glue
  import segglue_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] DISP_ADDR = 16'h7F55
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrStrobe,
  input  logic [DATA_W-1:0] busLow,
  input  logic [ADDR_W-DATA_W-1:0] busHigh,
  input  logic              fetchN,
  input  logic              readN,
  input  logic              writeN,
  output logic [ADDR_W-1:0] addrOut,
  output logic              sramSelN,
  output logic              sramOeN,
  output logic [DATA_W-1:0] segOut
);

  glueStrobes_t strobes;

  busCtrl #(.ADDR_W(ADDR_W), .DISP_ADDR(DISP_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .addrStrobe(addrStrobe),
    .fetchN(fetchN), .readN(readN), .writeN(writeN),
    .addrFull(addrOut), .strobes(strobes),
    .sramSelN(sramSelN), .sramOeN(sramOeN)
  );

  busDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .busLow(busLow), .busHigh(busHigh),
    .addrFull(addrOut), .segOut(segOut)
  );

endmodule

// File: tb/sim_segbus_glue.sv
module sim_segbus_glue;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam int NVEC       = 13;
  // {kind[1:0] (0 write,1 read,2 fetch), addr[15:0], data[7:0], expected seg[7:0]}
  localparam logic [33:0] VECS [NVEC] = '{
    {2'd0, 16'h7F55, 8'h3F, 8'h3F},
    {2'd0, 16'h7F54, 8'h11, 8'h3F},
    {2'd0, 16'hFF55, 8'h22, 8'h3F},
    {2'd0, 16'h7F57, 8'h33, 8'h3F},
    {2'd1, 16'h7F55, 8'h44, 8'h3F},
    {2'd2, 16'h7F55, 8'h55, 8'h3F},
    {2'd0, 16'h7F55, 8'h06, 8'h06},
    {2'd1, 16'h8000, 8'h77, 8'h06},
    {2'd0, 16'h7F55, 8'h00, 8'h00},
    {2'd0, 16'h6F55, 8'h5B, 8'h00},
    {2'd0, 16'h7F55, 8'h01, 8'h01},
    {2'd0, 16'h7F55, 8'h40, 8'h40},
    {2'd0, 16'h7E55, 8'h99, 8'h40}
  };

  logic clk = 0;
  logic rstN = 0;
  logic addrStrobe = 0;
  logic [7:0] busLow = 0;
  logic [7:0] busHigh = 0;
  logic fetchN = 1, readN = 1, writeN = 1;
  logic [15:0] addrOut;
  logic sramSelN, sramOeN;
  logic [7:0] segOut;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  segbus_glue u0 (
    .clk(clk), .rstN(rstN), .addrStrobe(addrStrobe), .busLow(busLow),
    .busHigh(busHigh), .fetchN(fetchN), .readN(readN), .writeN(writeN),
    .addrOut(addrOut), .sramSelN(sramSelN), .sramOeN(sramOeN), .segOut(segOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busCycle(input logic [1:0] kind, input logic [15:0] a,
                          input logic [7:0] d, input logic [7:0] expSeg);
    logic [7:0] prevSeg;
    prevSeg = segOut;
    @(negedge clk);
    addrStrobe = 1; busHigh = a[15:8]; busLow = a[7:0];
    #1 check("R1/R3 address during strobe", addrOut, a);
    @(negedge clk);
    addrStrobe = 0; busLow = d;
    #1 check("R2 address held after strobe", addrOut, a);
    check("R4 chip select", {15'd0, sramSelN}, {15'd0, a[15]});
    @(negedge clk);
    case (kind)
      2'd0: writeN = 0;
      2'd1: readN = 0;
      default: fetchN = 0;
    endcase
    #1 check("R5 output enable in cycle", {15'd0, sramOeN},
             {15'd0, (kind == 2'd0) ? 1'b1 : a[15]});
    @(negedge clk);
    check("R6 no load while write low", {8'd0, segOut}, {8'd0, prevSeg});
    writeN = 1; readN = 1; fetchN = 1;
    @(negedge clk);
    check("R6/R7/R10 display after cycle", {8'd0, segOut}, {8'd0, expSeg});
    check("R5 output enable idle", {15'd0, sramOeN}, 16'd1);
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 display at reset", {8'd0, segOut}, 16'h0000);
    check("R8 address at reset", addrOut, 16'h0000);
    rstN = 1;
    @(negedge clk);
    check("R4 select at zero address", {15'd0, sramSelN}, 16'd0);
    check("R5 enable idle at reset", {15'd0, sramOeN}, 16'd1);

    for (int i = 0; i < NVEC; i++)
      busCycle(VECS[i][33:32], VECS[i][31:16], VECS[i][15:8], VECS[i][7:0]);

    // R9: blank and single-segment patterns
    busCycle(2'd0, 16'h7F55, 8'h00, 8'h00);
    check("R9 all segments off", {8'd0, segOut}, 16'h0000);
    busCycle(2'd0, 16'h7F55, 8'h01, 8'h01);
    check("R9 segment a is bit 0", {8'd0, segOut}, 16'h0001);

    // R2: port changes after address phase do not disturb the address
    @(negedge clk);
    addrStrobe = 1; busHigh = 8'h12; busLow = 8'h34;
    @(negedge clk);
    addrStrobe = 0; busLow = 8'hC3;
    @(negedge clk);
    busLow = 8'h5A;
    #1 check("R2 held across port changes", addrOut, 16'h1234);
    busHigh = 8'h90;
    #1 check("R3 high byte follows port", addrOut, 16'h9034);
    check("R4 select off above 0x7FFF", {15'd0, sramSelN}, 16'd1);
    fetchN = 0;
    #1 check("R5 fetch above 0x7FFF not enabled", {15'd0, sramOeN}, 16'd1);
    fetchN = 1;

    // R8: reset mid-run clears the display
    busCycle(2'd0, 16'h7F55, 8'h7E, 8'h7E);
    @(negedge clk);
    rstN = 0;
    #1 check("R8 display cleared by reset", {8'd0, segOut}, 16'h0000);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule